// File: doc/BRIEF.md
# Neuron Backward Delta Unit

This unit produces the error term of one hidden neuron during the backward pass of back-propagation training. It walks over every neuron of the following layer. For each one it multiplies that neuron's delta by the weight linking it back to this neuron, and adds up the products. It then forms the slope of the logistic activation, S·(1−S), from this neuron's own activation, and scales the sum by that slope. For a neuron in the final hidden layer, the weighted sum is replaced by the output error (target − S). In that mode the sequence runs through exactly the same cycles, so the latency does not depend on where the layer sits.

Each neuron of a physical layer holds one instance, with its position in the layer given by a parameter. The weights come from the other neurons' stores, so the unit steps through the next layer in a fixed order. It starts one below its own position, counts down, wraps, and finishes on its own slot. This keeps the cross-neuron reads of all neurons in the layer on distinct indices in any one cycle. The unit owns no multiplier. It drives the operands of a multiplier shared with the rest of the neuron and reads back the full-width product in the same cycle. All values are signed fixed point with 16 integer and 16 fraction bits. Every product is rounded back to that format and saturated.

Top module: `neuron_delta_unit`

## Requirements
- R1: After reset `delta_out` is 0, `ready` is 0 and both multiplier operands are 0. The operands stay 0 whenever no computation is in progress.
- R2: Suppose `en` is sampled high at a clock edge while the unit is idle. Then `ready` is high for exactly one cycle, starting at the (NUM_NEURONS+2)-th edge after that one.
- R3: For NUM_NEURONS cycles after the start, the operands are delta and weight word i. Word i occupies bits [32i+31:32i]. The index i starts at (NEURON_ID−1) mod NUM_NEURONS, decrements with wrap from 0 to NUM_NEURONS−1, and ends at NEURON_ID.
- R4: In the next cycle the operands are S and 1−S. S is activation word NEURON_ID, and 1.0 is 0x00010000. 1−S is saturated to 32 bits.
- R5: Every product is rounded to nearest by adding 2^15 to the 64-bit product, shifting it right arithmetically by 16, and saturating the result to the signed 32-bit range.
- R6: For a hidden layer (`last_layer`=0), `delta_out` = rnd(sum · rnd(S·(1−S))). Here sum is the 32-bit-saturated total of the rounded delta·weight products.
- R7: With `last_layer`=1, sum is replaced by target − S saturated to 32 bits. The latency of R2 is unchanged.
- R8: `en` asserted while a computation is in progress is ignored: that run gives one `ready` pulse with the unchanged result.
- R9: `delta_out` changes only in the cycle in which `ready` rises. It holds its value while the inputs change with no start.
- R10: If the accumulated sum exceeds the 32-bit range, it saturates to 0x7FFFFFFF or 0x80000000 before the scaling multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Start request, taken only while idle |
| last_layer | input | 1 | Use target error instead of the weighted delta sum |
| target | input | 32 | Target value for the final hidden layer |
| delta_vec | input | NUM_NEURONS*32 | Deltas of the next layer, word i at bits 32i |
| weight_vec | input | NUM_NEURONS*32 | Weights from each next-layer neuron back to this one |
| act_vec | input | NUM_NEURONS*32 | Activations of this layer; word NEURON_ID is used |
| mul_a | output | 32 | First operand to the shared multiplier |
| mul_b | output | 32 | Second operand to the shared multiplier |
| mul_prod | input | 64 | Full signed product of mul_a and mul_b, same cycle |
| delta_out | output | 32 | Registered delta result |
| ready | output | 1 | One-cycle pulse when delta_out is updated |

## Verification
Two conditions are hard to bring about from the ports. The first is accumulator saturation, which needs several products that each already clip at the 32-bit limit. The stimulus table therefore holds rows in which every delta sits near the positive or negative limit and every weight is 2.0. The second is the wrap of the cross-access index past zero. The bench uses a neuron position of 1, so the index wraps after one step. It fills every activation slot other than this neuron's with a decoy, so a wrong order or a wrong activation selection shows up in the operands it watches cycle by cycle. A start request raised in the middle of a run covers the rule that a start is ignored while busy.

// File: rtl/ndu_pkg.sv
// Package: shared word format, state encoding and the rounding helpers of the
// backward delta unit. Assumes two's-complement fixed point words.
package ndu_pkg;
    parameter int unsigned DW = 32;          // word width
    parameter int unsigned FW = 16;          // fraction bits
    localparam int unsigned PW = 2 * DW;     // full product width

    typedef logic signed [DW-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACC   = 3'd1,
        ST_DERIV = 3'd2,
        ST_SCALE = 3'd3,
        ST_DONE  = 3'd4
    } ndu_state_e;

    localparam word_t ONE = word_t'(1 << FW);

    // Sign-extend a word to product width plus one.
    function automatic logic signed [PW:0] widen(input word_t w);
        return {{(PW+1-DW){w[DW-1]}}, w};
    endfunction

    // Clip a wide signed value into the word range.
    function automatic word_t sat_word(input logic signed [PW:0] v);
        logic signed [PW:0] hi;
        logic signed [PW:0] lo;
        hi = $signed({{(PW+2-DW){1'b0}}, {(DW-1){1'b1}}});
        lo = $signed({{(PW+2-DW){1'b1}}, {(DW-1){1'b0}}});
        if (v > hi)      return hi[DW-1:0];
        else if (v < lo) return lo[DW-1:0];
        else             return v[DW-1:0];
    endfunction

    // Round a full product to nearest (half up) and saturate to a word.
    function automatic word_t round_prod(input logic signed [PW-1:0] p);
        logic signed [PW:0] t;
        t = {p[PW-1], p} + {{(PW+1-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};
        return sat_word(t >>> FW);
    endfunction
endpackage

// File: rtl/ndu_ctrl.sv
// Sequencer: five-state control and the decrementing cross-access index.
// Assumes NEURON_ID < NUM_NEURONS; a start is taken only in the idle state.
module ndu_ctrl
    import ndu_pkg::*;
#(
    parameter int unsigned NUM_NEURONS = 4,
    parameter int unsigned NEURON_ID   = 1,
    localparam int unsigned IW = (NUM_NEURONS > 1) ? $clog2(NUM_NEURONS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output ndu_state_e    state,
    output logic [IW-1:0] idx
);
    localparam int unsigned START_IDX = (NEURON_ID + NUM_NEURONS - 1) % NUM_NEURONS;
    localparam logic [IW-1:0] LAST_IDX = IW'(NEURON_ID);
    localparam logic [IW-1:0] TOP_IDX  = IW'(NUM_NEURONS - 1);

    // Advance the state and walk the index downward with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (en) begin
                    state <= ST_ACC;
                    idx   <= IW'(START_IDX);
                end
                ST_ACC: begin
                    if (idx == LAST_IDX) state <= ST_DERIV;
                    else                 idx   <= (idx == '0) ? TOP_IDX : idx - 1'b1;
                end
                ST_DERIV: state <= ST_SCALE;
                ST_SCALE: state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ndu_operand_mux.sv
// Operand steering: picks what the shared multiplier sees in each state.
// Assumes vector inputs are held stable for the whole computation.
module ndu_operand_mux
    import ndu_pkg::*;
#(
    parameter int unsigned NUM_NEURONS = 4,
    localparam int unsigned IW = (NUM_NEURONS > 1) ? $clog2(NUM_NEURONS) : 1,
    localparam int unsigned VW = NUM_NEURONS * DW
) (
    input  ndu_state_e    state,
    input  logic [IW-1:0] idx,
    input  logic [VW-1:0] delta_vec,
    input  logic [VW-1:0] weight_vec,
    input  word_t         act,
    input  word_t         sum,
    input  word_t         deriv,
    output word_t         op_a,
    output word_t         op_b
);
    word_t d_w [NUM_NEURONS];
    word_t w_w [NUM_NEURONS];
    word_t one_minus;

    for (genvar g = 0; g < NUM_NEURONS; g++) begin : g_unpack
        assign d_w[g] = delta_vec[g*DW +: DW];
        assign w_w[g] = weight_vec[g*DW +: DW];
    end

    // 1 - S, clipped so a large negative S cannot wrap.
    assign one_minus = sat_word(widen(ONE) - widen(act));

    // Select the operand pair for the current state; zero when unused.
    always_comb begin
        op_a = '0;
        op_b = '0;
        unique case (state)
            ST_ACC: begin
                op_a = d_w[idx];
                op_b = w_w[idx];
            end
            ST_DERIV: begin
                op_a = act;
                op_b = one_minus;
            end
            ST_SCALE: begin
                op_a = sum;
                op_b = deriv;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ndu_datapath.sv
// Datapath: accumulates rounded products, keeps the derivative, forms the
// final delta and the ready pulse. Assumes the product arrives the same cycle.
module ndu_datapath
    import ndu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  ndu_state_e    state,
    input  logic          last_layer,
    input  word_t         target,
    input  word_t         act,
    input  logic [PW-1:0] prod,
    output word_t         sum,
    output word_t         deriv,
    output word_t         delta_q,
    output logic          ready_q
);
    logic signed [PW:0] acc;
    word_t              prod_r;

    assign prod_r = round_prod(prod);

    // Summation input: weighted delta total, or output error in last layer.
    assign sum = last_layer ? sat_word(widen(target) - widen(act)) : sat_word(acc);

    // Running sum of rounded delta-weight products.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acc <= '0;
        else if (state == ST_IDLE)  acc <= '0;
        else if (state == ST_ACC)   acc <= acc + widen(prod_r);
    end

    // Capture the activation slope during its single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 deriv <= '0;
        else if (state == ST_DERIV) deriv <= prod_r;
    end

    // Register the scaled delta and raise ready for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delta_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= (state == ST_SCALE);
            if (state == ST_SCALE) delta_q <= prod_r;
        end
    end
endmodule

// File: rtl/neuron_delta_unit.sv
// Top: back-propagation delta for one hidden neuron through a shared
// multiplier. Assumes inputs stay stable from start until ready.
module neuron_delta_unit
    import ndu_pkg::*;
#(
    parameter int unsigned NUM_NEURONS = 4,
    parameter int unsigned NEURON_ID   = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      last_layer,
    input  logic [DW-1:0]             target,
    input  logic [NUM_NEURONS*DW-1:0] delta_vec,
    input  logic [NUM_NEURONS*DW-1:0] weight_vec,
    input  logic [NUM_NEURONS*DW-1:0] act_vec,
    output logic [DW-1:0]             mul_a,
    output logic [DW-1:0]             mul_b,
    input  logic [2*DW-1:0]           mul_prod,
    output logic [DW-1:0]             delta_out,
    output logic                      ready
);
    localparam int unsigned IW = (NUM_NEURONS > 1) ? $clog2(NUM_NEURONS) : 1;

    ndu_state_e    state;
    logic [IW-1:0] idx;
    word_t         act, sum, deriv, op_a, op_b, delta_q;
    logic          ready_q;

    assign act       = act_vec[NEURON_ID*DW +: DW];
    assign mul_a     = op_a;
    assign mul_b     = op_b;
    assign delta_out = delta_q;
    assign ready     = ready_q;

    ndu_ctrl #(.NUM_NEURONS(NUM_NEURONS), .NEURON_ID(NEURON_ID)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .state(state), .idx(idx)
    );

    ndu_operand_mux #(.NUM_NEURONS(NUM_NEURONS)) u_mux (
        .state(state), .idx(idx), .delta_vec(delta_vec), .weight_vec(weight_vec),
        .act(act), .sum(sum), .deriv(deriv), .op_a(op_a), .op_b(op_b)
    );

    ndu_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .state(state), .last_layer(last_layer),
        .target(target), .act(act), .prod(mul_prod), .sum(sum), .deriv(deriv),
        .delta_q(delta_q), .ready_q(ready_q)
    );
endmodule

// File: rtl/ndu_checker.sv
// Checker: tracks runs from the ports and checks timing, operand order and
// output stability. Bound to every neuron_delta_unit instance.
module ndu_checker
    import ndu_pkg::*;
#(
    parameter int unsigned NUM_NEURONS = 4,
    parameter int unsigned NEURON_ID   = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      en,
    input logic [NUM_NEURONS*DW-1:0] delta_vec,
    input logic [NUM_NEURONS*DW-1:0] weight_vec,
    input logic [NUM_NEURONS*DW-1:0] act_vec,
    input logic [DW-1:0]             mul_a,
    input logic [DW-1:0]             mul_b,
    input logic [DW-1:0]             delta_out,
    input logic                      ready
);
    logic        busy;
    logic [15:0] cyc;
    int unsigned exp_idx;
    word_t       s_n;
    logic        s_in_range;

    // Independent run tracker: counts edges since an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cyc  <= '0;
        end else if (!busy) begin
            if (en) begin
                busy <= 1'b1;
                cyc  <= 16'd1;
            end
        end else if (ready) begin
            busy <= 1'b0;
            cyc  <= '0;
        end else begin
            cyc <= cyc + 16'd1;
        end
    end

    assign exp_idx    = (NEURON_ID + NUM_NEURONS - int'(cyc)) % NUM_NEURONS;
    assign s_n        = act_vec[NEURON_ID*DW +: DW];
    assign s_in_range = (s_n >= 0) && (s_n <= ONE);

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mul_a == '0 && mul_b == '0));

    p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_ready_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (busy && int'(cyc) == NUM_NEURONS + 3));

    p_cross_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cyc >= 16'd1 && int'(cyc) <= NUM_NEURONS) |->
        (mul_a == delta_vec[exp_idx*DW +: DW] && mul_b == weight_vec[exp_idx*DW +: DW]));

    p_slope_ops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && int'(cyc) == NUM_NEURONS + 1 && s_in_range) |->
        (mul_a == s_n && mul_b == ONE - s_n));

    p_hold_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(ready) |-> $stable(delta_out));
endmodule

bind neuron_delta_unit ndu_checker #(
    .NUM_NEURONS(NUM_NEURONS), .NEURON_ID(NEURON_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .delta_vec(delta_vec),
    .weight_vec(weight_vec), .act_vec(act_vec), .mul_a(mul_a), .mul_b(mul_b),
    .delta_out(delta_out), .ready(ready)
);

// File: tb/neuron_delta_unit_tb.sv
`timescale 1ns/1ps
module neuron_delta_unit_tb;
    localparam int NN  = 4;
    localparam int NID = 1;
    localparam logic [31:0] DECOY = 32'h1234_0000;

    typedef struct packed {
        logic [3:0]           req;
        logic                 last;
        logic [31:0]          target;
        logic [31:0]          act;
        logic [NN-1:0][31:0]  d;
        logic [NN-1:0][31:0]  w;
    } vec_t;

    // Stimulus rows; expected results come from the model below.
    localparam vec_t TBL [6] = '{
        // R6: mixed-sign hidden neuron
        '{4'd6, 1'b0, 32'h0, 32'h0000_8000,
          {32'h0002_0000, 32'hFFFF_C000, 32'h0000_8000, 32'h0001_0000},
          {32'hFFFF_0000, 32'h0001_0000, 32'h0000_8000, 32'h0000_8000}},
        // R7: last layer, positive error
        '{4'd7, 1'b1, 32'h0001_0000, 32'h0000_C000,
          {32'h0005_0000, 32'h0005_0000, 32'h0005_0000, 32'h0005_0000},
          {32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000}},
        // R10: positive accumulator saturation
        '{4'd10, 1'b0, 32'h0, 32'h0000_8000,
          {32'h7FFF_0000, 32'h7FFF_0000, 32'h7FFF_0000, 32'h7FFF_0000},
          {32'h0002_0000, 32'h0002_0000, 32'h0002_0000, 32'h0002_0000}},
        // R10: negative accumulator saturation
        '{4'd10, 1'b0, 32'h0, 32'h0000_4000,
          {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
          {32'h0002_0000, 32'h0002_0000, 32'h0002_0000, 32'h0002_0000}},
        // R5: half-way products round up
        '{4'd5, 1'b0, 32'h0, 32'h0000_8000,
          {32'h0000_0000, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0001},
          {32'h0000_0000, 32'h0000_8000, 32'h0000_8000, 32'h0000_8000}},
        // R7: last layer, negative error
        '{4'd7, 1'b1, 32'h0, 32'h0000_3000,
          {32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000},
          {32'h0001_0000, 32'h0001_0000, 32'h0001_0000, 32'h0001_0000}}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                en = 1'b0;
    logic                last_layer = 1'b0;
    logic [31:0]         target = '0;
    logic [NN*32-1:0]    delta_vec = '0;
    logic [NN*32-1:0]    weight_vec = '0;
    logic [NN*32-1:0]    act_vec = '0;
    logic signed [31:0]  mul_a, mul_b;
    logic signed [63:0]  mul_prod;
    logic [31:0]         delta_out;
    logic                ready;
    int                  errors = 0;
    int                  checks = 0;

    always #2 clk = ~clk;

    assign mul_prod = mul_a * mul_b;   // shared multiplier model

    neuron_delta_unit #(.NUM_NEURONS(NN), .NEURON_ID(NID)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .last_layer(last_layer),
        .target(target), .delta_vec(delta_vec), .weight_vec(weight_vec),
        .act_vec(act_vec), .mul_a(mul_a), .mul_b(mul_b), .mul_prod(mul_prod),
        .delta_out(delta_out), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act_v,
                         input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    function automatic longint clip(input longint v);
        if (v > 64'sd2147483647)  return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint rnd(input longint a, input longint b);
        return clip((a * b + 32768) >>> 16);
    endfunction

    function automatic logic [31:0] model(input vec_t v);
        longint acc = 0, s, der, sum;
        s = longint'($signed(v.act));
        for (int i = 0; i < NN; i++)
            acc += rnd(longint'($signed(v.d[i])), longint'($signed(v.w[i])));
        sum = v.last ? clip(longint'($signed(v.target)) - s) : clip(acc);
        der = rnd(s, clip(65536 - s));
        return 32'(rnd(sum, der));
    endfunction

    task automatic apply(input vec_t v);
        last_layer = v.last;
        target     = v.target;
        delta_vec  = v.d;
        weight_vec = v.w;
        for (int i = 0; i < NN; i++)
            act_vec[i*32 +: 32] = (i == NID) ? v.act : DECOY;
    endtask

    // Run one computation, watching operands each cycle and the ready pulse.
    task automatic run(input vec_t v, input bit extra_en);
        int lat = 0, pulses = 0;
        logic [31:0] got = '0;
        string tag;
        tag = $sformatf("R%0d", v.req);
        apply(v);
        @(negedge clk); en = 1'b1;
        @(negedge clk); en = 1'b0;
        for (int k = 1; k <= NN + 6; k++) begin
            if (k > 1) @(negedge clk);
            if (extra_en) en = (k == 2);       // R8: start while busy
            if (k <= NN) begin
                int i = (NID + NN - k) % NN;
                check(mul_a == v.d[i] && mul_b == v.w[i], "R3 operand order",
                      {mul_a, mul_b}, {v.d[i], v.w[i]});
            end
            if (k == NN + 1)
                check(mul_a == v.act && mul_b == 32'h0001_0000 - v.act, "R4 slope operands",
                      {mul_a, mul_b}, {v.act, 32'h0001_0000 - v.act});
            if (ready) begin
                pulses++;
                if (pulses == 1) begin lat = k; got = delta_out; end
            end
        end
        en = 1'b0;
        check(lat == NN + 3 && pulses == 1, "R2 latency/pulse", 64'(lat), 64'(NN + 3));
        check(got == model(v), tag, 64'(got), 64'(model(v)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(delta_out == 0 && ready == 0 && mul_a == 0 && mul_b == 0, "R1 reset",
              {delta_out, 31'(0), ready}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mul_a == 0 && mul_b == 0, "R1 idle operands", {mul_a, mul_b}, 64'd0);

        for (int n = 0; n < 6; n++) run(TBL[n], 1'b0);

        // R8: a second start during a run is ignored
        run(TBL[0], 1'b1);
        repeat (NN + 4) begin
            @(negedge clk);
            check(ready == 1'b0, "R8 no extra pulse", 64'(ready), 64'd0);
        end

        // R9: output holds while inputs change without a start
        apply(TBL[2]);
        repeat (6) begin
            @(negedge clk);
            check(delta_out == model(TBL[0]) && ready == 1'b0, "R9 hold",
                  64'(delta_out), 64'(model(TBL[0])));
        end

        // R1: reset in idle clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check(delta_out == 0 && ready == 0, "R1 reset clears", 64'(delta_out), 64'd0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule